// File: doc/BRIEF.md
# Decimal Switch-Programmed Clock Divider

This block divides an input clock by a decimal divisor N between 1 and 9999. The divisor comes from four 4-bit BCD digit codes, usually wired to thumbwheel switches. For every N enabled clock cycles the block emits one pulse that lasts a single cycle. The pulse is a clock enable for downstream logic and is not a new clock.

The internal count is a chain of BCD digits that counts down. Each digit wraps from 0 to 9 and borrows from the digit above it. The switch codes therefore load straight into the counter and need no conversion to binary. A period is loaded only when the previous period ends. If the switches move in the middle of a count, the current period runs to its end, and the new value is used from the next reload.

Top module: `bcd_clk_div`

## Requirements
- R1: `digits_i[4k+3:4k]` carries decimal digit k, and digit 0 (bits 3:0) is the least significant. For example, 16'h0021 selects N = 21.
- R2: With a valid N and `en_i` held high, `pulse_o` is high for one cycle after every N-th enabled clock edge counted from reset. It is low on all other cycles.
- R3: With N = 1, `pulse_o` is high in every cycle that follows an enabled edge.
- R4: An edge with `en_i` low leaves the count unchanged, and `pulse_o` is low in the cycle after it. Only enabled edges advance the count.
- R5: A divisor is invalid when all digits are 0 or when any digit code is 1010 to 1111. While an invalid divisor is present at a reload point, `pulse_o` stays low and no count starts. Once the divisor becomes valid, a full period of the new N begins.
- R6: A change of `digits_i` during a count does not alter the current period. It takes effect from the period that follows the next pulse.
- R7: Reset (`rst_ni` low) forces `pulse_o` low at once. After release, the first period starts from the switch value present at the first enabled edge.
- R8: N = 9999 gives a period of exactly 9999 cycles, with borrows running through all four digits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable |
| digits_i | input | 16 | Divisor as four BCD digits, least significant digit in bits 3:0 |
| pulse_o | output | 1 | Single-cycle pulse, once every N enabled cycles |

## Verification
The only visible effect of the internal state is the timing of pulses. A corrupted digit or a lost borrow moves the next pulse and every pulse after it, so a fault shows up at the latest within one period of N cycles. A missed reload or a wrong enable gate either makes the period wrong at the very first pulse, or produces a pulse where the bench predicts none. The bench therefore compares the output on every cycle with a decimal model of the period and also counts the total number of pulses.

// File: rtl/bcd_div_pkg.sv
package bcd_div_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned DIGIT_MAX = 9;
  typedef logic [DIGIT_W-1:0] bcd_t;
endpackage

// File: rtl/bcd_digit_dec.sv
module bcd_digit_dec
  import bcd_div_pkg::*;
(
  input  bcd_t d_i,
  input  logic borrow_i,
  output bcd_t q_o,
  output logic borrow_o
);
  logic at_zero;
  assign at_zero  = (d_i == '0);
  assign borrow_o = borrow_i & at_zero;
  always_comb begin
    q_o = d_i;
    if (borrow_i) q_o = at_zero ? bcd_t'(DIGIT_MAX) : d_i - bcd_t'(1);
  end
endmodule

// File: rtl/bcd_value_check.sv
module bcd_value_check
  import bcd_div_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 4,
  localparam int unsigned VAL_W = NUM_DIGITS * DIGIT_W
) (
  input  logic [VAL_W-1:0] val_i,
  output logic             valid_o,
  output logic             one_o
);
  logic [NUM_DIGITS-1:0] dig_ok;
  logic [NUM_DIGITS-1:0] dig_zero;

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_dig
    assign dig_ok[k]   = (val_i[k*DIGIT_W +: DIGIT_W] <= bcd_t'(DIGIT_MAX));
    assign dig_zero[k] = (val_i[k*DIGIT_W +: DIGIT_W] == '0);
  end

  assign valid_o = (&dig_ok) & ~(&dig_zero);
  if (NUM_DIGITS > 1) begin : g_multi
    assign one_o = (val_i[DIGIT_W-1:0] == bcd_t'(1)) & (&dig_zero[NUM_DIGITS-1:1]);
  end else begin : g_single
    assign one_o = (val_i[DIGIT_W-1:0] == bcd_t'(1));
  end
endmodule

// File: rtl/bcd_clk_div.sv
module bcd_clk_div
  import bcd_div_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 4,
  localparam int unsigned VAL_W = NUM_DIGITS * DIGIT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [VAL_W-1:0] digits_i,
  output logic             pulse_o
);
  logic [VAL_W-1:0]    cnt_q, cur, dec;
  logic                load_q, pulse_q;
  logic                cur_valid, cur_one;
  logic [NUM_DIGITS:0] borrow;

  // reload point: switches are read only here
  assign cur = load_q ? digits_i : cnt_q;

  bcd_value_check #(.NUM_DIGITS(NUM_DIGITS)) i_check (
    .val_i   (cur),
    .valid_o (cur_valid),
    .one_o   (cur_one)
  );

  assign borrow[0] = 1'b1;
  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_chain
    bcd_digit_dec i_dec (
      .d_i      (cur[k*DIGIT_W +: DIGIT_W]),
      .borrow_i (borrow[k]),
      .q_o      (dec[k*DIGIT_W +: DIGIT_W]),
      .borrow_o (borrow[k+1])
    );

    AST_DIGIT_BCD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_q |-> (cnt_q[k*DIGIT_W +: DIGIT_W] <= bcd_t'(DIGIT_MAX))); // R8
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      load_q  <= 1'b1;
      pulse_q <= 1'b0;
    end else if (en_i) begin
      if (load_q && !cur_valid) begin
        pulse_q <= 1'b0;          // hold at reload point
      end else if (cur_one) begin
        pulse_q <= 1'b1;
        load_q  <= 1'b1;
      end else begin
        cnt_q   <= dec;
        load_q  <= 1'b0;
        pulse_q <= 1'b0;
      end
    end else begin
      pulse_q <= 1'b0;
    end
  end

  assign pulse_o = pulse_q;

  AST_PULSE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> $past(en_i)); // R4
  AST_FREEZE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(cnt_q) && $stable(load_q) && !pulse_o)); // R4
  AST_INVALID_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && load_q && !cur_valid) |=> (!pulse_o && load_q)); // R5
  AST_UNIT_DIVISOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && load_q && digits_i == VAL_W'(1)) |=> pulse_o); // R3
  AST_PULSE_RELOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> load_q); // R2
endmodule

// File: tb/test_bcd_clk_div.sv
module test_bcd_clk_div;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b1;
  logic [15:0] digits_i = 16'h0005;
  logic        pulse_o;

  int total = 0;
  int bad = 0;
  int e = 0;
  int cur_n = 0;

  always #10 clk = ~clk;

  bcd_clk_div i_bcd_clk_div (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .digits_i (digits_i),
    .pulse_o  (pulse_o)
  );

  function automatic int bcd_val(input logic [15:0] v);
    int r = 0;
    for (int k = 3; k >= 0; k--) begin
      if (v[k*4 +: 4] > 4'd9) return -1;
      r = r * 10 + int'(v[k*4 +: 4]);
    end
    return (r == 0) ? -1 : r;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle, called at a negedge; compares at the following negedge
  task automatic step(input logic en_v, output int mism, output int pulsed);
    logic exp = 1'b0;
    int v;
    en_i = en_v;
    @(posedge clk);
    if (en_v) begin
      if (e == 0) begin
        v = bcd_val(digits_i);
        if (v > 0) begin
          cur_n = v;
          e = 1;
        end
      end else begin
        e++;
      end
      if (e != 0 && e == cur_n) begin
        exp = 1'b1;
        e = 0;
      end
    end
    @(negedge clk);
    mism = (pulse_o !== exp) ? 1 : 0;
    pulsed = (pulse_o === 1'b1) ? 1 : 0;
  endtask

  // en_mode 0: always enabled; 1: disabled every third cycle
  task automatic run(input int cycles, input int en_mode, input int exp_pulses, input string tag);
    int mism_total = 0;
    int pulses = 0;
    int m, p;
    for (int i = 0; i < cycles; i++) begin
      step((en_mode == 1 && (i % 3) == 2) ? 1'b0 : 1'b1, m, p);
      mism_total += m;
      pulses += p;
    end
    en_i = 1'b1;
    chk(mism_total == 0, {tag, " cycle pattern"}, mism_total, 0);
    chk(pulses == exp_pulses, {tag, " pulse count"}, pulses, exp_pulses);
  endtask

  task automatic do_reset(input logic [15:0] sw);
    @(negedge clk);
    digits_i = sw;
    rst_ni = 1'b0;
    #1;
    chk(pulse_o === 1'b0, "R7 pulse low in reset", int'(pulse_o), 0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    e = 0;
  endtask

  task automatic t_basic;
    do_reset(16'h0005);
    run(50, 0, 10, "R2 N=5");
    do_reset(16'h0010);
    run(100, 0, 10, "R2 N=10 borrow");
  endtask

  task automatic t_digit_order;
    do_reset(16'h0021);
    run(84, 0, 4, "R1 N=21 digit order");
    do_reset(16'h0037);
    run(111, 0, 3, "R1 N=37");
  endtask

  task automatic t_unit;
    do_reset(16'h0001);
    run(20, 0, 20, "R3 N=1");
  endtask

  task automatic t_enable;
    do_reset(16'h0004);
    run(60, 1, 10, "R4 gated enable");
  endtask

  task automatic t_invalid;
    do_reset(16'h0000);
    run(20, 0, 0, "R5 zero divisor");
    digits_i = 16'h0003;
    run(9, 0, 3, "R5 valid after zero");
    digits_i = 16'h00A2;
    run(10, 0, 0, "R5 non-BCD digit");
    digits_i = 16'h0002;
    run(4, 0, 2, "R5 recover");
  endtask

  task automatic t_change;
    do_reset(16'h0007);
    run(3, 0, 0, "R6 before change");
    digits_i = 16'h0004;
    run(12, 0, 3, "R6 change at reload");
  endtask

  task automatic t_reset_mid;
    do_reset(16'h0006);
    run(4, 0, 0, "R7 partial count");
    do_reset(16'h0006);
    run(12, 0, 2, "R7 restart after reset");
  endtask

  task automatic t_max;
    do_reset(16'h9999);
    run(19998, 0, 2, "R8 N=9999");
  endtask

  initial begin
    t_basic();
    t_digit_order();
    t_unit();
    t_enable();
    t_invalid();
    t_change();
    t_reset_mid();
    t_max();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule